// File: doc/BRIEF.md
# Dual-Port Dataflow Issue Queue

This block is the scheduling window between decode and a pair of single-cycle integer ALUs. Each operation arrives with an opcode, a destination tag and up to two source tags, each source with its own enable. The block stores up to eight operations in arrival order. When an operation arrives, each enabled source is compared against the destination tags of the older operations still in the window. The youngest match, if it has not yet executed, becomes that source's producer.

Every entry steps through waiting, ready, running and done. Each cycle the two oldest ready entries are sent out on the two issue ports. An issued operation runs for one cycle. Its destination tag then appears on the broadcast port of the same number, and any entry waiting on it becomes ready at that same clock edge. So a dependent operation leaves on an issue port in the cycle after its producer's broadcast, and younger independent work can pass an older stalled operation. Completed entries leave the window from the oldest end, at most two per cycle, which makes room for new arrivals. When all slots are occupied, `full` is raised and arrivals are refused.

Top module: `iq_issue_queue`

## Requirements
- R1: While reset is high, and in the first cycle after it falls with no arrival, `iss_valid`, `bcast_valid` and `full` are all 0 and no slot is occupied.
- R2: An operation with no outstanding source, sampled on clock edge k, appears on an issue port after edge k+1. Every accepted operation is eventually issued exactly once, with its own opcode and destination tag.
- R3: An operation shown on issue port p in one cycle appears in the next cycle on broadcast port p with its destination tag. A broadcast port is never valid without that preceding issue.
- R4: An enabled source whose tag matches a not-yet-executed older operation holds its entry back. The entry leaves on an issue port in the cycle right after the producer's broadcast, and no earlier.
- R5: When more than two entries are ready, the two oldest are issued, the older on port 0 (`iss_valid` bit 0). Port 1 is used only when port 0 is also used in the same cycle.
- R6: A younger operation with no outstanding source issues ahead of an older operation that is still waiting.
- R7: `full` is high exactly when all DEPTH slots are occupied. An arrival presented while `full` is high is dropped and never issued.
- R8: Slots are freed only from the oldest end once the entries there are done, up to two per cycle. `full` falls in the cycle after the oldest entry is freed.
- R9: When several older entries share a source's tag, the dependency is on the youngest of them. If that one is already running or done, the source counts as available.
- R10: A source whose enable bit is 0 is ignored, whatever its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Arrival request |
| enq_op | input | OP_W | Opcode of the arriving operation |
| enq_src0_en | input | 1 | Source 0 is used |
| enq_src0 | input | TAG_W | Source 0 tag |
| enq_src1_en | input | 1 | Source 1 is used |
| enq_src1 | input | TAG_W | Source 1 tag |
| enq_dst | input | TAG_W | Destination tag |
| full | output | 1 | All slots occupied; arrivals refused |
| iss_valid | output | 2 | Issue port valid, bit p for port p |
| iss_op | output | 2 x OP_W | Opcode per issue port |
| iss_src0 | output | 2 x TAG_W | Source 0 tag per issue port |
| iss_src1 | output | 2 x TAG_W | Source 1 tag per issue port |
| iss_dst | output | 2 x TAG_W | Destination tag per issue port |
| bcast_valid | output | 2 | Completion broadcast valid per port |
| bcast_tag | output | 2 x TAG_W | Completed destination tag per port |

## Verification
Four properties are checked on every cycle: broadcasts follow issues one-for-one on the same port, port 1 never fires alone, the occupied-slot count agrees with the per-slot valid bits, and `full` tracks that count. Everything that depends on the dependency graph is shown only by the bench's scenarios, each with hand-derived issue cycles. That covers wake-up timing, youngest-producer matching, ignored source enables, oldest-first choice among three ready entries, and bypass of a stalled chain. The bench also fills the window with a slow chain to show that it refuses an arrival and then frees space in order.

// File: rtl/iq_pkg.sv
package iq_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_READY = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } iq_state_e;
endpackage

// File: rtl/iq_pick2.sv
// Picks the two oldest requesting slots, counting age from base.
module iq_pick2 #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic [DEPTH-1:0]          req,
  input  logic [IDX_W-1:0]          base,
  output logic [1:0]                gnt_v,
  output logic [1:0][IDX_W-1:0]     gnt_idx
);
  logic [IDX_W-1:0] rot_idx [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rot
    assign rot_idx[g] = base + IDX_W'(g);
  end

  always_comb begin
    gnt_v   = '0;
    gnt_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (req[rot_idx[i]]) begin
        if (!gnt_v[0]) begin
          gnt_v[0]   = 1'b1;
          gnt_idx[0] = rot_idx[i];
        end else if (!gnt_v[1]) begin
          gnt_v[1]   = 1'b1;
          gnt_idx[1] = rot_idx[i];
        end
      end
    end
  end
endmodule

// File: rtl/iq_dep_lookup.sv
// Finds the youngest occupied slot whose destination matches a source tag.
module iq_dep_lookup #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 8,
  parameter int IDX_W = 3
) (
  input  logic [DEPTH-1:0]            occ,
  input  logic [DEPTH-1:0]            live,
  input  logic [DEPTH-1:0][TAG_W-1:0] dst_tag,
  input  logic [IDX_W-1:0]            base,
  input  logic                        src_en,
  input  logic [TAG_W-1:0]            src_tag,
  output logic                        pend,
  output logic [IDX_W-1:0]            prod_idx
);
  logic [IDX_W-1:0] rot_idx [DEPTH];
  logic             hit;
  logic             hit_live;

  for (genvar g = 0; g < DEPTH; g++) begin : g_rot
    assign rot_idx[g] = base + IDX_W'(g);
  end

  // scan oldest to youngest; the last match wins
  always_comb begin
    hit      = 1'b0;
    hit_live = 1'b0;
    prod_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (occ[rot_idx[i]] && dst_tag[rot_idx[i]] == src_tag) begin
        hit      = 1'b1;
        hit_live = live[rot_idx[i]];
        prod_idx = rot_idx[i];
      end
    end
  end

  assign pend = src_en && hit && hit_live;
endmodule

// File: rtl/iq_issue_queue.sv
module iq_issue_queue #(
  parameter int DEPTH = 8,   // power of two, at least 2
  parameter int TAG_W = 8,
  parameter int OP_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  enq_valid,
  input  logic [OP_W-1:0]       enq_op,
  input  logic                  enq_src0_en,
  input  logic [TAG_W-1:0]      enq_src0,
  input  logic                  enq_src1_en,
  input  logic [TAG_W-1:0]      enq_src1,
  input  logic [TAG_W-1:0]      enq_dst,
  output logic                  full,
  output logic [1:0]            iss_valid,
  output logic [1:0][OP_W-1:0]  iss_op,
  output logic [1:0][TAG_W-1:0] iss_src0,
  output logic [1:0][TAG_W-1:0] iss_src1,
  output logic [1:0][TAG_W-1:0] iss_dst,
  output logic [1:0]            bcast_valid,
  output logic [1:0][TAG_W-1:0] bcast_tag
);
  import iq_pkg::*;

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  // slot storage
  logic [DEPTH-1:0]            ent_vld;
  iq_state_e                   ent_st   [DEPTH];
  logic [OP_W-1:0]             ent_op   [DEPTH];
  logic [DEPTH-1:0][TAG_W-1:0] ent_dst;
  logic [TAG_W-1:0]            ent_s0   [DEPTH];
  logic [TAG_W-1:0]            ent_s1   [DEPTH];
  logic [1:0]                  ent_pend [DEPTH];
  logic [IDX_W-1:0]            ent_prod [DEPTH][2];

  logic [IDX_W-1:0] head;
  logic [CNT_W-1:0] count;

  // slot classification
  logic [DEPTH-1:0] live_m, ready_m, run_m, take_m, free_m;
  logic [1:0]       pend_nxt [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      live_m[i]  = ent_vld[i] && (ent_st[i] == ST_WAIT || ent_st[i] == ST_READY);
      ready_m[i] = ent_vld[i] && (ent_st[i] == ST_READY);
      run_m[i]   = ent_vld[i] && (ent_st[i] == ST_RUN);
    end
  end

  // wake-up: a pending source clears when its producer finishes this edge
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      for (int s = 0; s < 2; s++) begin
        pend_nxt[i][s] = ent_pend[i][s] && !run_m[ent_prod[i][s]];
      end
    end
  end

  // dependency lookup for both arriving sources
  logic [1:0]            lk_en;
  logic [1:0][TAG_W-1:0] lk_tag;
  logic [1:0]            lk_pend;
  logic [1:0][IDX_W-1:0] lk_prod;

  assign lk_en  = {enq_src1_en, enq_src0_en};
  assign lk_tag = {enq_src1, enq_src0};

  for (genvar s = 0; s < 2; s++) begin : g_lookup
    iq_dep_lookup #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_lookup (
      .occ      (ent_vld),
      .live     (live_m),
      .dst_tag  (ent_dst),
      .base     (head),
      .src_en   (lk_en[s]),
      .src_tag  (lk_tag[s]),
      .pend     (lk_pend[s]),
      .prod_idx (lk_prod[s])
    );
  end

  // issue selection and completion ordering
  logic [1:0]            sel_v, cmp_v;
  logic [1:0][IDX_W-1:0] sel_idx, cmp_idx;

  iq_pick2 #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_select (
    .req (ready_m), .base (head), .gnt_v (sel_v), .gnt_idx (sel_idx)
  );

  iq_pick2 #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_complete (
    .req (run_m), .base (head), .gnt_v (cmp_v), .gnt_idx (cmp_idx)
  );

  // in-order retirement from the head, up to two per cycle
  logic [IDX_W-1:0] head_nx1;
  logic [IDX_W-1:0] tail;
  logic             ret0, ret1, enq_acc;
  logic [1:0]       nret;
  logic [CNT_W-1:0] count_next;

  assign head_nx1   = head + IDX_W'(1);
  assign tail       = head + count[IDX_W-1:0];
  assign ret0       = ent_vld[head] && ent_st[head] == ST_DONE;
  assign ret1       = ret0 && ent_vld[head_nx1] && ent_st[head_nx1] == ST_DONE;
  assign nret       = {1'b0, ret0} + {1'b0, ret1};
  assign enq_acc    = enq_valid && !full;
  assign count_next = count + CNT_W'(enq_acc) - CNT_W'(nret);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      take_m[i] = (sel_v[0] && sel_idx[0] == IDX_W'(i)) ||
                  (sel_v[1] && sel_idx[1] == IDX_W'(i));
      free_m[i] = (ret0 && head == IDX_W'(i)) ||
                  (ret1 && head_nx1 == IDX_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld     <= '0;
      head        <= '0;
      count       <= '0;
      full        <= 1'b0;
      iss_valid   <= '0;
      bcast_valid <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ent_vld[i]) begin
          unique case (ent_st[i])
            ST_WAIT: begin
              ent_pend[i] <= pend_nxt[i];
              if (pend_nxt[i] == 2'b00) ent_st[i] <= ST_READY;
            end
            ST_READY: if (take_m[i]) ent_st[i] <= ST_RUN;
            ST_RUN:   ent_st[i] <= ST_DONE;
            default:  ;
          endcase
          if (free_m[i]) ent_vld[i] <= 1'b0;
        end else if (enq_acc && tail == IDX_W'(i)) begin
          ent_vld[i]     <= 1'b1;
          ent_st[i]      <= (lk_pend != 2'b00) ? ST_WAIT : ST_READY;
          ent_op[i]      <= enq_op;
          ent_dst[i]     <= enq_dst;
          ent_s0[i]      <= enq_src0;
          ent_s1[i]      <= enq_src1;
          ent_pend[i]    <= lk_pend;
          ent_prod[i][0] <= lk_prod[0];
          ent_prod[i][1] <= lk_prod[1];
        end
      end
      head        <= head + IDX_W'(nret);
      count       <= count_next;
      full        <= (count_next == CNT_W'(DEPTH));
      iss_valid   <= sel_v;
      bcast_valid <= cmp_v;
    end
  end

  // output payload registers, no reset needed
  always_ff @(posedge clk) begin
    for (int p = 0; p < 2; p++) begin
      iss_op[p]    <= ent_op[sel_idx[p]];
      iss_src0[p]  <= ent_s0[sel_idx[p]];
      iss_src1[p]  <= ent_s1[sel_idx[p]];
      iss_dst[p]   <= ent_dst[sel_idx[p]];
      bcast_tag[p] <= ent_dst[cmp_idx[p]];
    end
  end
endmodule

// File: rtl/iq_issue_queue_chk.sv
module iq_issue_queue_chk #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 8,
  parameter int CNT_W = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic [1:0]            iss_valid,
  input logic [1:0][TAG_W-1:0] iss_dst,
  input logic [1:0]            bcast_valid,
  input logic [1:0][TAG_W-1:0] bcast_tag,
  input logic                  full,
  input logic [CNT_W-1:0]      count,
  input logic [DEPTH-1:0]      ent_vld
);
  // R1: outputs quiet when reset releases
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (iss_valid == 2'b00 && bcast_valid == 2'b00 && !full));

  // R3: each issue is followed by a broadcast of its tag on the same port
  a_r3_bcast_after_iss0: assert property (@(posedge clk) disable iff (rst)
    iss_valid[0] |=> (bcast_valid[0] && bcast_tag[0] == $past(iss_dst[0])));
  a_r3_bcast_after_iss1: assert property (@(posedge clk) disable iff (rst)
    iss_valid[1] |=> (bcast_valid[1] && bcast_tag[1] == $past(iss_dst[1])));
  a_r3_no_bcast_alone: assert property (@(posedge clk) disable iff (rst)
    (bcast_valid != 2'b00) |-> ($past(iss_valid) == bcast_valid));

  // R5: port 1 only alongside port 0
  a_r5_port_order: assert property (@(posedge clk) disable iff (rst)
    iss_valid[1] |-> iss_valid[0]);

  // R7: full flag agrees with occupancy
  a_r7_full_matches: assert property (@(posedge clk) disable iff (rst)
    full == (count == CNT_W'(DEPTH)));

  // R8: occupancy counter agrees with slot valid bits
  a_r8_count_matches: assert property (@(posedge clk) disable iff (rst)
    $countones(ent_vld) == int'(count));
endmodule

bind iq_issue_queue iq_issue_queue_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .iss_valid   (iss_valid),
  .iss_dst     (iss_dst),
  .bcast_valid (bcast_valid),
  .bcast_tag   (bcast_tag),
  .full        (full),
  .count       (count),
  .ent_vld     (ent_vld)
);

// File: tb/iq_issue_queue_tb.sv
module iq_issue_queue_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst;
  logic            enq_valid;
  logic [3:0]      enq_op;
  logic            enq_src0_en, enq_src1_en;
  logic [7:0]      enq_src0, enq_src1, enq_dst;
  logic            full;
  logic [1:0]      iss_valid, bcast_valid;
  logic [1:0][3:0] iss_op;
  logic [1:0][7:0] iss_src0, iss_src1, iss_dst, bcast_tag;

  iq_issue_queue u_dut (
    .clk (clk), .rst (rst),
    .enq_valid (enq_valid), .enq_op (enq_op),
    .enq_src0_en (enq_src0_en), .enq_src0 (enq_src0),
    .enq_src1_en (enq_src1_en), .enq_src1 (enq_src1),
    .enq_dst (enq_dst), .full (full),
    .iss_valid (iss_valid), .iss_op (iss_op),
    .iss_src0 (iss_src0), .iss_src1 (iss_src1), .iss_dst (iss_dst),
    .bcast_valid (bcast_valid), .bcast_tag (bcast_tag)
  );

  typedef struct {
    int cyc;
    int port;
    int dst;
    int req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   mon_on = 1'b0;
  bit   seen_drop = 1'b0;
  bit   finished = 1'b0;
  logic [1:0] prev_v = 2'b00;
  logic [7:0] prev_dst [2];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic expect_iss(input int c, input int p, input int d, input int r);
    exp_t e;
    e.cyc = c; e.port = p; e.dst = d; e.req = r;
    q.push_back(e);
  endtask

  // drive one arrival for a cycle; opcode is the low nibble of the tag
  task automatic put(input bit s0e, input int s0, input bit s1e, input int s1, input int d);
    enq_valid   = 1'b1;
    enq_op      = d[3:0];
    enq_src0_en = s0e;
    enq_src0    = s0[7:0];
    enq_src1_en = s1e;
    enq_src1    = s1[7:0];
    enq_dst     = d[7:0];
    @(negedge clk);
  endtask

  task automatic idle();
    enq_valid = 1'b0;
  endtask

  // scoreboard monitor: issue order and timing, broadcast after issue
  always @(negedge clk) begin
    if (mon_on) begin
      for (int p = 0; p < 2; p++) begin
        while (q.size() > 0 && q[0].cyc < cyc) begin
          checks++; failures++;
          $display("FAIL R%0d: port %0d actual=none expected dst %0d at cycle %0d",
                   q[0].req, q[0].port, q[0].dst, q[0].cyc);
          void'(q.pop_front());
        end
        if (iss_valid[p]) begin
          checks++;
          if (iss_dst[p] == 8'd99) seen_drop = 1'b1;
          if (q.size() > 0 && q[0].cyc == cyc && q[0].port == p) begin
            if (iss_dst[p] != q[0].dst[7:0] || iss_op[p] != q[0].dst[3:0]) begin
              failures++;
              $display("FAIL R%0d: port %0d cycle %0d actual dst %0d op %0d expected dst %0d",
                       q[0].req, p, cyc, iss_dst[p], iss_op[p], q[0].dst);
            end
            void'(q.pop_front());
          end else begin
            failures++;
            $display("FAIL R6: port %0d cycle %0d actual dst %0d expected no issue",
                     p, cyc, iss_dst[p]);
          end
        end else if (q.size() > 0 && q[0].cyc == cyc && q[0].port == p) begin
          checks++; failures++;
          $display("FAIL R%0d: port %0d cycle %0d actual=none expected dst %0d",
                   q[0].req, p, cyc, q[0].dst);
          void'(q.pop_front());
        end
        // R3: broadcast mirrors the previous cycle's issue
        if (prev_v[p] || bcast_valid[p]) begin
          checks++;
          if (bcast_valid[p] != prev_v[p] || (prev_v[p] && bcast_tag[p] != prev_dst[p])) begin
            failures++;
            $display("FAIL R3: port %0d actual valid %0d tag %0d expected valid %0d tag %0d",
                     p, bcast_valid[p], bcast_tag[p], prev_v[p], prev_dst[p]);
          end
        end
      end
      prev_v      = iss_valid;
      prev_dst[0] = iss_dst[0];
      prev_dst[1] = iss_dst[1];
    end
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int b;
    int k;
    rst = 1'b1;
    idle();
    enq_op = '0; enq_src0_en = 1'b0; enq_src1_en = 1'b0;
    enq_src0 = '0; enq_src1 = '0; enq_dst = '0;
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    chk(iss_valid == 2'b00, "R1", iss_valid, 0);
    chk(bcast_valid == 2'b00, "R1", bcast_valid, 0);
    chk(full == 1'b0, "R1", full, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(iss_valid == 2'b00 && full == 1'b0, "R1", {full, iss_valid}, 0);
    mon_on = 1'b1;

    // R2: lone independent op
    b = cyc;
    expect_iss(b + 2, 0, 10, 2);
    put(0, 0, 0, 0, 10);
    idle();
    repeat (10) @(negedge clk);

    // R4 and R6: chain 20 -> 21 -> 22 with independent 23 passing 22
    b = cyc;
    expect_iss(b + 2, 0, 20, 4);
    expect_iss(b + 4, 0, 21, 4);
    expect_iss(b + 5, 0, 23, 6);
    expect_iss(b + 6, 0, 22, 4);
    put(0, 0, 0, 0, 20);
    put(1, 20, 0, 0, 21);
    put(0, 0, 1, 21, 22);
    put(0, 0, 0, 0, 23);
    idle();
    repeat (12) @(negedge clk);

    // R5: three consumers of 41 become ready together
    b = cyc;
    expect_iss(b + 2, 0, 40, 2);
    expect_iss(b + 4, 0, 41, 4);
    expect_iss(b + 6, 0, 42, 5);
    expect_iss(b + 6, 1, 43, 5);
    expect_iss(b + 7, 0, 44, 5);
    put(0, 0, 0, 0, 40);
    put(1, 40, 0, 0, 41);
    put(1, 41, 0, 0, 42);
    put(0, 0, 1, 41, 43);
    put(1, 41, 0, 0, 44);
    idle();
    repeat (12) @(negedge clk);

    // R10: disabled sources carrying a live tag do not stall
    b = cyc;
    expect_iss(b + 2, 0, 60, 2);
    expect_iss(b + 3, 0, 61, 10);
    put(0, 0, 0, 0, 60);
    put(0, 60, 0, 60, 61);
    idle();
    repeat (10) @(negedge clk);

    // R9: consumer of tag 70 waits for the youngest writer of 70
    b = cyc;
    expect_iss(b + 2, 0, 70, 2);
    expect_iss(b + 4, 0, 70, 4);
    expect_iss(b + 6, 0, 71, 9);
    put(0, 0, 0, 0, 70);
    put(1, 70, 0, 0, 70);
    put(1, 70, 0, 0, 71);
    idle();
    repeat (12) @(negedge clk);

    // R7 and R8: a chain fills the window, one arrival is refused
    b = cyc;
    k = 0;
    while (!full && k < 40) begin
      expect_iss(b + 2 + 2 * k, 0, 100 + k, 8);
      if (k == 0) put(0, 0, 0, 0, 100);
      else        put(1, 100 + k - 1, 0, 0, 100 + k);
      k++;
    end
    chk(k == 13, "R7", k, 13);
    chk(full == 1'b1, "R7", full, 1);
    put(0, 0, 0, 0, 99);
    idle();
    chk(full == 1'b0, "R8", full, 0);
    repeat (40) @(negedge clk);

    chk(q.size() == 0, "R2", q.size(), 0);
    chk(!seen_drop, "R7", seen_drop, 0);
    chk(full == 1'b0 && iss_valid == 2'b00, "R8", {full, iss_valid}, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule